// File: doc/BRIEF.md
# Interrupt Pending and Priority Selector

This block keeps a pending flag and a programmable priority for each of 32 interrupt lines, and names the line that should be served next. A rising edge on a line's input marks it pending. Software reads and clears the pending flags through one 32-bit register. It programs priorities through eight 32-bit registers, each holding four byte-wide fields. Only the two top bits of each field are stored, so the usable priority levels are 0, 64, 128 and 192.

Every cycle a selector compares all pending lines. The winning line number and a valid flag come out of registers one cycle after the state they are based on. The register port is a plain synchronous write port with a combinational read path. It has no handshake and never applies back-pressure: a write takes effect at the clock edge where `bus_we` is high, and `bus_rdata` reflects the current state of the addressed register.

Top module: `irq_pend_sel`

## Requirements
- R1: A write to byte offset 0x280 clears every pending flag whose data bit is 1; data bits that are 0 leave their flags unchanged.
- R2: A read of offset 0x280 returns the pending flags, bit i being line i, with 1 meaning pending.
- R3: Priority register n (n = 0..7) sits at offset 0x400 + 4n; its byte field k, bits [8k+7:8k], belongs to line 4n+k.
- R4: Only bits [7:6] of each priority field are stored; bits [5:0] read as zero whatever was written, so writing 0xFF to a field reads back 0xC0.
- R5: Among pending lines, the one with the smallest priority value wins.
- R6: A 0-to-1 transition on an interrupt input sets that line's pending flag; an input held high does not set the flag again after it is cleared.
- R7: When a rising edge and a clear of the same line fall in the same cycle, the line ends up pending.
- R8: When several pending lines share the smallest priority value, the smallest line number wins.
- R9: `win_id` and `win_valid` are registered and reflect the pending and priority state one clock after it changes; `win_valid` is 0 and `win_id` is 0 when no line is pending.
- R10: After reset all pending flags and all priority fields are 0 and `win_valid` is 0.
- R11: Writes to any other offset, or to an offset not aligned to a word, change no state; reads of such offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, one write per cycle high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| irq_in | input | 32 | Interrupt inputs, one per line, edge-detected |
| win_id | output | 5 | Number of the selected pending line |
| win_valid | output | 1 | High when at least one line is pending |

## Verification
A new rising edge on a line and a software clear of that same line can land in one cycle. The bench provokes this by raising a line's input in the cycle that writes its bit to the clear register, and expects the flag to survive and that line to win. It then repeats the clear while the input stays high and expects the flag to drop. Both outcomes are judged through the read-back of the pending register and through the registered winner outputs two edges after the stimulus.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  // Default geometry of the selector
  localparam int unsigned LINES_DEF    = 32;
  localparam int unsigned WORD_W_DEF   = 32;
  localparam int unsigned FIELD_W_DEF  = 8;
  localparam int unsigned KEEP_W_DEF   = 2;
  localparam int unsigned ADDR_W_DEF   = 12;
  // Register offsets (bytes)
  localparam logic [11:0] CLR_OFS_DEF  = 12'h280;
  localparam logic [11:0] PRIO_OFS_DEF = 12'h400;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_i,
  input  logic [LINES-1:0] clr_i,
  output logic [LINES-1:0] pend_o
);
  logic [LINES-1:0] prev_q;
  logic [LINES-1:0] pend_q;
  logic [LINES-1:0] rise;

  assign rise = irq_i & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= irq_i;
  end

  // one flag per line; an edge overrides a clear in the same cycle
  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)       pend_q[g] <= 1'b0;
      else if (rise[g]) pend_q[g] <= 1'b1;
      else if (clr_i[g]) pend_q[g] <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(rise & clr_i)) & ~pend_q) == '0)); // R7
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(clr_i & ~rise)) == '0)); // R1
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(rise)) == '0)); // R6
endmodule

// File: rtl/irq_prio_bank.sv
module irq_prio_bank #(
  parameter int unsigned LINES   = 32,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned KEEP_W  = 2,
  localparam int unsigned PER_WORD = WORD_W / FIELD_W,
  localparam int unsigned N_REGS   = LINES / PER_WORD,
  localparam int unsigned REG_AW   = (N_REGS > 1) ? $clog2(N_REGS) : 1,
  localparam int unsigned LOW_W    = FIELD_W - KEEP_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [REG_AW-1:0]       wr_word,
  input  logic [WORD_W-1:0]       wdata,
  input  logic [REG_AW-1:0]       rd_word,
  output logic [WORD_W-1:0]       rd_data,
  output logic [LINES*KEEP_W-1:0] prio_o
);
  logic [KEEP_W-1:0] prio_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_field
    localparam int unsigned REG_IDX = g / PER_WORD;
    localparam int unsigned SLOT    = g % PER_WORD;
    localparam int unsigned TOP_BIT = SLOT * FIELD_W + FIELD_W - 1;
    always_ff @(posedge clk) begin
      if (!rst_n)
        prio_q[g] <= '0;
      else if (wr_en && (wr_word == REG_AW'(REG_IDX)))
        prio_q[g] <= wdata[TOP_BIT -: KEEP_W];
    end
    assign prio_o[g*KEEP_W +: KEEP_W] = prio_q[g];
  end

  // discarded low bits of every field
  logic sink_unused_low;
  always_comb begin
    sink_unused_low = 1'b0;
    for (int k = 0; k < int'(PER_WORD); k++)
      sink_unused_low = sink_unused_low ^ (^wdata[k*FIELD_W +: LOW_W]);
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < int'(PER_WORD); k++)
      rd_data[k*FIELD_W +: FIELD_W] =
        {prio_q[int'(rd_word)*int'(PER_WORD) + k], {LOW_W{1'b0}}};
  end

  AST_PRIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(prio_o)); // R3
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned LINES  = 32,
  parameter int unsigned KEEP_W = 2,
  localparam int unsigned ID_W  = $clog2(LINES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LINES-1:0]        pend_i,
  input  logic [LINES*KEEP_W-1:0] prio_i,
  output logic [ID_W-1:0]         win_id_o,
  output logic                    win_valid_o
);
  logic [ID_W-1:0]   best_id;
  logic [KEEP_W-1:0] best_pr;
  logic              found;

  // lowest value wins; strict compare keeps the lowest index on ties
  always_comb begin
    best_id = '0;
    best_pr = '0;
    found   = 1'b0;
    for (int i = 0; i < int'(LINES); i++) begin
      if (pend_i[i] && (!found || (prio_i[i*KEEP_W +: KEEP_W] < best_pr))) begin
        found   = 1'b1;
        best_id = ID_W'(i);
        best_pr = prio_i[i*KEEP_W +: KEEP_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_id_o    <= '0;
      win_valid_o <= 1'b0;
    end else begin
      win_id_o    <= best_id;
      win_valid_o <= found;
    end
  end

  AST_WIN_WAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> ((($past(pend_i) >> win_id_o) & LINES'(1)) != '0)); // R9
  AST_IDLE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend_i) == '0) |-> !win_valid_o); // R9
  AST_IDLE_ID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid_o |-> (win_id_o == '0)); // R9
endmodule

// File: rtl/irq_pend_sel.sv
module irq_pend_sel
  import irq_sel_pkg::*;
#(
  parameter int unsigned LINES    = LINES_DEF,
  parameter int unsigned WORD_W   = WORD_W_DEF,
  parameter int unsigned FIELD_W  = FIELD_W_DEF,
  parameter int unsigned KEEP_W   = KEEP_W_DEF,
  parameter int unsigned ADDR_W   = ADDR_W_DEF,
  parameter logic [ADDR_W-1:0] CLR_OFS  = ADDR_W'(CLR_OFS_DEF),
  parameter logic [ADDR_W-1:0] PRIO_OFS = ADDR_W'(PRIO_OFS_DEF),
  localparam int unsigned PER_WORD = WORD_W / FIELD_W,
  localparam int unsigned N_REGS   = LINES / PER_WORD,
  localparam int unsigned REG_AW   = (N_REGS > 1) ? $clog2(N_REGS) : 1,
  localparam int unsigned ID_W     = $clog2(LINES),
  localparam logic [ADDR_W-1:0] PRIO_END = PRIO_OFS + ADDR_W'(N_REGS * 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [LINES-1:0]  irq_in,
  output logic [ID_W-1:0]   win_id,
  output logic              win_valid
);
  logic              hit_clr;
  logic              hit_prio;
  logic [REG_AW-1:0] word_idx;
  logic [LINES-1:0]  clr_vec;
  logic [LINES-1:0]  pend;
  logic [LINES*KEEP_W-1:0] prio_flat;
  logic [WORD_W-1:0] prio_rd;

  assign hit_clr  = (bus_addr == CLR_OFS);
  assign hit_prio = (bus_addr >= PRIO_OFS) && (bus_addr < PRIO_END) &&
                    (bus_addr[1:0] == 2'b00);
  assign word_idx = bus_addr[REG_AW+1:2];
  assign clr_vec  = (bus_we && hit_clr) ? bus_wdata[LINES-1:0] : '0;

  irq_pend_bank #(.LINES(LINES)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_i  (irq_in),
    .clr_i  (clr_vec),
    .pend_o (pend)
  );

  irq_prio_bank #(
    .LINES(LINES), .WORD_W(WORD_W), .FIELD_W(FIELD_W), .KEEP_W(KEEP_W)
  ) u_prio (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_we && hit_prio),
    .wr_word (word_idx),
    .wdata   (bus_wdata),
    .rd_word (word_idx),
    .rd_data (prio_rd),
    .prio_o  (prio_flat)
  );

  irq_pick #(.LINES(LINES), .KEEP_W(KEEP_W)) u_pick (
    .clk         (clk),
    .rst_n       (rst_n),
    .pend_i      (pend),
    .prio_i      (prio_flat),
    .win_id_o    (win_id),
    .win_valid_o (win_valid)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit_clr)       bus_rdata[LINES-1:0] = pend;
    else if (hit_prio) bus_rdata = prio_rd;
  end

  function automatic logic [WORD_W-1:0] low_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int k = 0; k < int'(PER_WORD); k++)
      m[k*FIELD_W +: (FIELD_W-KEEP_W)] = '1;
    return m;
  endfunction

  AST_PRIO_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hit_prio |-> ((bus_rdata & low_mask()) == '0)); // R4
endmodule

// File: tb/irq_pend_sel_bench.sv
`timescale 1ns/1ps
module irq_pend_sel_bench;
  localparam logic [11:0] CLR  = 12'h280;
  localparam logic [11:0] PBAS = 12'h400;

  typedef struct {
    int         due;
    logic       v;
    logic [4:0] id;
    int         req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_in = '0;
  logic [4:0]  win_id;
  logic        win_valid;

  irq_pend_sel u_irq_pend_sel (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .win_id(win_id), .win_valid(win_valid)
  );

  always #2.5 clk = ~clk;

  int   cyc = 0;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 0;
  exp_t q[$];

  logic [31:0] pend_m = '0;
  logic [31:0] prev_m = '0;
  logic [1:0]  pm [32];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit is_prio(logic [11:0] a);
    return (a >= PBAS) && (a < PBAS + 12'h20) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [31:0] model_rd(logic [11:0] a);
    logic [31:0] r;
    r = '0;
    if (a == CLR) r = pend_m;
    else if (is_prio(a))
      for (int k = 0; k < 4; k++) r[k*8 +: 8] = {pm[int'(a[4:2])*4 + k], 6'b0};
    return r;
  endfunction

  // advance the model by one edge and queue the outputs expected one edge later
  task automatic model_edge(logic [31:0] irq, logic we, logic [11:0] a,
                            logic [31:0] d, int req);
    logic [31:0] rise, clr;
    exp_t e;
    int   bp;
    rise = irq & ~prev_m;
    clr  = (we && a == CLR) ? d : '0;
    pend_m = (pend_m & ~clr) | rise;
    if (we && is_prio(a))
      for (int k = 0; k < 4; k++) pm[int'(a[4:2])*4 + k] = d[k*8+6 +: 2];
    prev_m = irq;
    e.due = cyc + 2; e.v = 1'b0; e.id = '0; e.req = req; bp = 4;
    for (int i = 0; i < 32; i++)
      if (pend_m[i] && int'(pm[i]) < bp) begin
        bp = int'(pm[i]); e.v = 1'b1; e.id = 5'(i);
      end
    q.push_back(e);
  endtask

  task automatic step(logic [31:0] irq, logic we, logic [11:0] a,
                      logic [31:0] d, int req);
    @(negedge clk);
    irq_in = irq; bus_we = we; bus_addr = a; bus_wdata = d;
    model_edge(irq, we, a, d, req);
  endtask

  task automatic rd(logic [11:0] a, string tag);
    logic [31:0] ex;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a; bus_wdata = '0;
    #1;
    ex = model_rd(a);
    n_vec++;
    if (bus_rdata !== ex) begin
      n_bad++;
      $display("FAIL %s read 0x%03h: got %08h expected %08h", tag, a, bus_rdata, ex);
    end
    model_edge(irq_in, 1'b0, a, '0, 9);
  endtask

  // monitor: compare winner outputs against queued expectations
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if (win_valid !== e.v || win_id !== e.id) begin
        n_bad++;
        $display("FAIL R%0d winner: got v=%0b id=%0d expected v=%0b id=%0d",
                 e.req, win_valid, win_id, e.v, e.id);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) pm[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: everything zero after reset
    rd(CLR, "R10");
    for (int n = 0; n < 8; n++) rd(PBAS + 12'(4*n), "R10");
    // R6: pulse on line 5 sets it pending
    step(32'h1 << 5, 1'b0, '0, '0, 6);
    step(32'h0, 1'b0, '0, '0, 6);
    rd(CLR, "R2");
    // R8: equal priorities, lowest number wins (3 over 5 and 10)
    step((32'h1 << 3) | (32'h1 << 10), 1'b0, '0, '0, 8);
    step(32'h0, 1'b0, '0, '0, 8);
    // R4: all-ones into register 0 reads back 0xC0 per field
    step(32'h0, 1'b1, PBAS, 32'hFFFF_FFFF, 4);
    rd(PBAS, "R4");
    // R3: field 1 of register 1 is line 5; R5: line 10 (value 0) now wins
    step(32'h0, 1'b1, PBAS + 12'h4, 32'h0000_7F00, 3);
    rd(PBAS + 12'h4, "R3");
    step(32'h0, 1'b0, '0, '0, 5);
    // R1: clearing line 10, then a zero write that changes nothing
    step(32'h0, 1'b1, CLR, 32'h1 << 10, 1);
    step(32'h0, 1'b1, CLR, 32'h0, 1);
    rd(CLR, "R1");
    // R7: edge and clear on line 20 in one cycle, flag survives
    step(32'h1 << 20, 1'b1, CLR, 32'h1 << 20, 7);
    rd(CLR, "R7");
    // R6: clear while input held high, no new set
    step(32'h1 << 20, 1'b1, CLR, 32'h1 << 20, 6);
    step(32'h1 << 20, 1'b0, '0, '0, 6);
    rd(CLR, "R6");
    step(32'h0, 1'b0, '0, '0, 6);
    // R3: register 7, top field is line 31
    step(32'h0, 1'b1, PBAS + 12'h1C, 32'h00FF_FFFF, 3);
    step((32'h1 << 31) | (32'h1 << 28), 1'b0, '0, '0, 3);
    rd(PBAS + 12'h1C, "R3");
    step(32'h0, 1'b0, '0, '0, 5);
    // R11: unmapped and unaligned writes are ignored
    step(32'h0, 1'b1, 12'h300, 32'hFFFF_FFFF, 11);
    step(32'h0, 1'b1, PBAS + 12'h2, 32'h0000_0000, 11);
    step(32'h0, 1'b1, CLR + 12'h1, 32'hFFFF_FFFF, 11);
    rd(12'h300, "R11");
    rd(PBAS, "R11");
    rd(CLR, "R11");
    // R9: clear everything, valid drops
    step(32'h0, 1'b1, CLR, 32'hFFFF_FFFF, 9);
    rd(CLR, "R9");
    repeat (4) step(32'h0, 1'b0, '0, '0, 9);
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule